// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block schedules and sequences DRAM refresh for a memory bus controller. A programmable prescaler divides the bus clock into counting ticks. An 8-bit interval counter advances on each tick and is compared against a programmable period. Each match asks the bus arbiter for the bus. Once the arbiter grants it, the block issues a programmable burst of CAS-before-RAS refresh cycles on its own strobe outputs.

A second mode puts the DRAM into self-refresh for low-power data retention. The strobes stay low for as long as that mode is selected. On exit, a precharge gap is enforced before the bus is returned.

Software programs the block through a small register write port:

| Address | Bits | Field |
|---|---|---|
| 0 | 0 | enable |
| 0 | 1 | self-refresh select |
| 1 | 2:0 | clock code |
| 1 | 5:3 | burst code |
| 1 | 7 | match flag (write 0 to clear) |
| 2 | 7:0 | period value |

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are 1, `ref_req` is 0, `interval_count` is 0 and `match_flag` is 0.
- R2: While the enable bit (address 0, bit 0) is 0, `interval_count` is held at 0 and no new refresh request is raised.
- R3: The clock code (address 1, bits 2:0) selects a tick divide of 2, 8, 32, 128, 512, 2048 or 4096 for codes 1 to 7. Code 0 stops the counter. In distributed mode, refresh requests therefore start every (period+1)×divide bus clocks.
- R4: On a tick where `interval_count` equals the period value (address 2), the counter returns to 0 and `match_flag` is set. Otherwise the counter increments by one on each tick, so it never exceeds the period when started from 0.
- R5: `match_flag` stays set until a write to address 1 with bit 7 equal to 0. A write to address 1 with bit 7 equal to 1 leaves the flag unchanged.
- R6: A refresh starts by raising `ref_req`. The strobes stay high until `ref_gnt` is seen high, and no strobe is driven low while `ref_req` is low.
- R7: Each CAS-before-RAS cycle has four phases:
  - CAS alone low for 1 clock;
  - both strobes low for 2 clocks;
  - both strobes released together;
  - both strobes high for 2 clocks of precharge.
- R8: The burst code (address 1, bits 5:3) gives 1, 2, 4, 6 or 8 consecutive refresh cycles for codes 0 to 4. Codes 5 to 7 give 8.
- R9: `ref_req` falls on the clock after the precharge of the last refresh of a burst.
- R10: With enable and self-refresh select both 1 (distributed mode is enable 1 and select 0), the block requests the bus. After the grant it drives CAS low, then RAS low one clock later, and holds both low while the mode stays selected.
- R11: Leaving self-refresh raises RAS and CAS in the same clock and keeps both high with `ref_req` still set for 2 clocks. `ref_req` then falls.
- R12: While self-refresh is selected, `interval_count` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ref_gnt | input | 1 | Bus grant from the arbiter |
| ref_req | output | 1 | Bus request for refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| interval_count | output | 8 | Current interval counter value |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The assertions assume that the arbiter holds `ref_gnt` once it has granted, until `ref_req` falls. The bench keeps the grant steady through each whole burst or self-refresh episode. The sticky-flag and counter-hold properties assume that register writes arrive only through the write port, with no other path to the fields. The bench quiesces the block before each scenario so that the counter starts from zero: it clears enable and waits for the request to drop. It then changes the mode bits only while no burst is in flight, except for the deliberate self-refresh exit.

// File: rtl/refresh_pkg.sv
// Shared types and field decoders for the DRAM refresh controller.
// Assumes the clock code and burst code are 3 bits wide.
package refresh_pkg;

    // Sequencer states for distributed and self-refresh operation.
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_REQ     = 3'd1,
        S_CAS     = 3'd2,
        S_RAS     = 3'd3,
        S_PRE     = 3'd4,
        S_SR_CAS  = 3'd5,
        S_SR_HOLD = 3'd6,
        S_SR_PRE  = 3'd7
    } seq_state_t;

    // Terminal prescaler value (divide minus one) for a clock code; 0 means stopped.
    function automatic logic [11:0] div_limit(input logic [2:0] code);
        case (code)
            3'd1:    div_limit = 12'd1;
            3'd2:    div_limit = 12'd7;
            3'd3:    div_limit = 12'd31;
            3'd4:    div_limit = 12'd127;
            3'd5:    div_limit = 12'd511;
            3'd6:    div_limit = 12'd2047;
            3'd7:    div_limit = 12'd4095;
            default: div_limit = 12'd0;
        endcase
    endfunction

    // Number of refreshes after the first one in a burst, for a burst code.
    function automatic logic [2:0] burst_extra(input logic [2:0] code);
        case (code)
            3'd0:    burst_extra = 3'd0;
            3'd1:    burst_extra = 3'd1;
            3'd2:    burst_extra = 3'd3;
            3'd3:    burst_extra = 3'd5;
            default: burst_extra = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/refresh_regs.sv
// Configuration registers of the refresh controller.
// Decodes single-cycle writes; a write to the timing register with the
// flag bit at 0 produces a one-cycle clear pulse for the match flag.
module refresh_regs #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_en,
    output logic              cfg_self,
    output logic [2:0]        cfg_clk_code,
    output logic [2:0]        cfg_burst_code,
    output logic [CNT_W-1:0]  cfg_period,
    output logic              flag_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(2);
    localparam int FLAG_BIT = DATA_W - 1;

    // Capture control, timing and period fields on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en         <= 1'b0;
            cfg_self       <= 1'b0;
            cfg_clk_code   <= 3'd0;
            cfg_burst_code <= 3'd0;
            cfg_period     <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                cfg_en   <= wr_data[0];
                cfg_self <= wr_data[1];
            end
            if (wr_addr == A_TIMING) begin
                cfg_clk_code   <= wr_data[2:0];
                cfg_burst_code <= wr_data[5:3];
            end
            if (wr_addr == A_PERIOD) begin
                cfg_period <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Flag clear request: a timing write with the flag bit at zero.
    assign flag_clr = wr_en && (wr_addr == A_TIMING) && !wr_data[FLAG_BIT];

endmodule

// File: rtl/refresh_prescale.sv
// Bus-clock prescaler producing one-cycle counting ticks.
// Assumes the clock code is static while running; a stop clears the phase.
module refresh_prescale #(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] clk_code,
    output logic       tick
);
    import refresh_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             active;

    assign limit  = PRE_W'(div_limit(clk_code));
    assign active = run && (clk_code != 3'd0);
    assign tick   = active && (pre_q == limit);

    // Advance the divide phase, wrapping at the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/refresh_interval.sv
// Interval counter with period compare and sticky match flag.
// Assumes tick is a single-cycle pulse; the counter is held at 0 when not running.
module refresh_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             match,
    output logic             flag
);
    logic hit;

    assign hit = run && tick && (count == period);

    // Count ticks, restarting from zero after a period match.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else if (hit) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // Register a one-cycle match pulse toward the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match <= 1'b0;
        end else begin
            match <= hit;
        end
    end

    // Sticky status flag: set on match, cleared by software, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/refresh_seq.sv
// Refresh strobe sequencer: request/grant handshake, bursts of
// CAS-before-RAS cycles, and self-refresh entry and exit.
// Assumes the grant, once given, is held until the request falls.
module refresh_seq #(
    parameter int LEFT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       self_sel,
    input  logic [2:0] burst_code,
    input  logic       match,
    input  logic       gnt,
    output logic       req,
    output logic       ras_n,
    output logic       cas_n
);
    import refresh_pkg::*;

    seq_state_t        state;
    logic              kind_self;
    logic              phase;
    logic [LEFT_W-1:0] left;
    logic              pend;
    logic              self_on;
    logic              dist_on;
    logic              take;

    assign self_on = en && self_sel;
    assign dist_on = en && !self_sel;
    assign take    = (state == S_IDLE) && !self_on && dist_on && pend;

    // Remember a period match until the sequencer can serve it.
    always_ff @(posedge clk) begin
        if (!rst_n || !dist_on) begin
            pend <= 1'b0;
        end else if (match) begin
            pend <= 1'b1;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind_self <= 1'b0;
            phase     <= 1'b0;
            left      <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    phase <= 1'b0;
                    if (self_on) begin
                        kind_self <= 1'b1;
                        state     <= S_REQ;
                    end else if (take) begin
                        kind_self <= 1'b0;
                        left      <= LEFT_W'(burst_extra(burst_code));
                        state     <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (kind_self && !self_on) begin
                        state <= S_IDLE;
                    end else if (gnt) begin
                        state <= kind_self ? S_SR_CAS : S_CAS;
                    end
                end
                S_CAS: begin
                    phase <= 1'b0;
                    state <= S_RAS;
                end
                S_RAS: begin
                    phase <= ~phase;
                    if (phase) begin
                        state <= S_PRE;
                    end
                end
                S_PRE: begin
                    phase <= ~phase;
                    if (phase) begin
                        if (left != '0) begin
                            left  <= left - 1'b1;
                            state <= S_CAS;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_SR_CAS: begin
                    state <= S_SR_HOLD;
                end
                S_SR_HOLD: begin
                    phase <= 1'b0;
                    if (!self_on) begin
                        state <= S_SR_PRE;
                    end
                end
                S_SR_PRE: begin
                    phase <= ~phase;
                    if (phase) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Strobe and request decode from the current state.
    always_comb begin
        req   = (state != S_IDLE);
        cas_n = !((state == S_CAS) || (state == S_RAS) ||
                  (state == S_SR_CAS) || (state == S_SR_HOLD));
        ras_n = !((state == S_RAS) || (state == S_SR_HOLD));
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Top of the DRAM refresh controller: registers, prescaler, interval
// counter and strobe sequencer. Assumes a single bus clock and that the
// arbiter holds its grant until the request is withdrawn.
module dram_refresh_ctrl #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ras_n,
    output logic              cas_n,
    output logic [CNT_W-1:0]  interval_count,
    output logic              match_flag
);
    localparam int LEFT_W = 3;

    logic             cfg_en;
    logic             cfg_self;
    logic [2:0]       cfg_clk_code;
    logic [2:0]       cfg_burst_code;
    logic [CNT_W-1:0] cfg_period;
    logic             flag_clr;
    logic             count_run;
    logic             tick;
    logic             match;

    assign count_run = cfg_en && !cfg_self;

    refresh_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_en(cfg_en), .cfg_self(cfg_self),
        .cfg_clk_code(cfg_clk_code), .cfg_burst_code(cfg_burst_code),
        .cfg_period(cfg_period), .flag_clr(flag_clr)
    );

    refresh_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(count_run),
        .clk_code(cfg_clk_code), .tick(tick)
    );

    refresh_interval #(.CNT_W(CNT_W)) u_ivl (
        .clk(clk), .rst_n(rst_n), .run(count_run), .tick(tick),
        .period(cfg_period), .flag_clr(flag_clr), .count(interval_count),
        .match(match), .flag(match_flag)
    );

    refresh_seq #(.LEFT_W(LEFT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .self_sel(cfg_self),
        .burst_code(cfg_burst_code), .match(match), .gnt(ref_gnt),
        .req(ref_req), .ras_n(ras_n), .cas_n(cas_n)
    );

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
// Property checker for the refresh controller, bound to its top.
// Assumes the grant is held for a whole refresh episode.
module dram_refresh_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ras_n,
    input logic             cas_n,
    input logic             cfg_en,
    input logic             cfg_self,
    input logic             flag_clr,
    input logic [CNT_W-1:0] interval_count,
    input logic             match_flag
);
    // RAS is never low without CAS also low.
    p_ras_with_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // RAS only falls when CAS was already low a clock earlier.
    p_cas_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(cas_n));

    // After RAS rises, both strobes stay high for two clocks.
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_n && cas_n) ##1 (ras_n && cas_n));

    // Strobes are only driven while the bus is requested.
    p_strobe_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> ref_req);

    // Request drops only after a precharge clock.
    p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> (ras_n && cas_n && $past(ras_n) && $past(cas_n)));

    // Counter stays at zero while enable is off.
    p_cnt_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_en) |-> (interval_count == '0));

    // Counter stays at zero while self-refresh is selected.
    p_cnt_self_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_self) |-> (interval_count == '0));

    // Flag only falls after a clear request.
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(match_flag) |-> $past(flag_clr));

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .cfg_en(cfg_en), .cfg_self(cfg_self),
    .flag_clr(flag_clr), .interval_count(interval_count),
    .match_flag(match_flag)
);

// File: tb/dram_refresh_ctrl_tb.sv
// Directed bench for the DRAM refresh controller.
module dram_refresh_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ref_gnt = 1'b0;
    logic       ref_req;
    logic       ras_n;
    logic       cas_n;
    logic [7:0] interval_count;
    logic       match_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ras_n(ras_n), .cas_n(cas_n), .interval_count(interval_count),
        .match_flag(match_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Disable the block and wait for any request to finish.
    task automatic quiesce();
        reg_write(2'd0, 8'h00);
        for (int i = 0; i < 200 && ref_req; i++) @(negedge clk);
    endtask

    task automatic wait_req(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (ref_req) begin seen = 1'b1; break; end
        end
    endtask

    // From the negedge showing the request (grant held), check n refreshes.
    task automatic check_train(input string req, input int n);
        int errs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); if (!(cas_n == 0 && ras_n == 1)) errs++;
            @(negedge clk); if (!(cas_n == 0 && ras_n == 0)) errs++;
            @(negedge clk); if (!(cas_n == 0 && ras_n == 0)) errs++;
            @(negedge clk); if (!(cas_n == 1 && ras_n == 1 && ref_req)) errs++;
            @(negedge clk); if (!(cas_n == 1 && ras_n == 1 && ref_req)) errs++;
        end
        check({req, " strobe pattern errors"}, errs, 0);
        @(negedge clk);
        check("R9 request released after last precharge", ref_req, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ras_n", ras_n, 1);
        check("R1 cas_n", cas_n, 1);
        check("R1 ref_req", ref_req, 0);
        check("R1 count", interval_count, 0);
        check("R1 flag", match_flag, 0);
    endtask

    task automatic t_disabled();
        int reqs = 0;
        reg_write(2'd2, 8'd1);
        reg_write(2'd1, 8'h81);
        ref_gnt = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ref_req || interval_count != 0) reqs++;
        end
        check("R2 disabled: no request, count held", reqs, 0);
    endtask

    task automatic t_code_zero();
        int moved = 0;
        quiesce();
        reg_write(2'd1, 8'h80);
        reg_write(2'd0, 8'h01);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ref_req || interval_count != 0) moved++;
        end
        check("R3 clock code 0 stops counter", moved, 0);
    endtask

    task automatic t_interval(input logic [2:0] code, input logic [7:0] per, input int expd);
        bit seen;
        int t1, t2;
        quiesce();
        ref_gnt = 1'b1;
        reg_write(2'd2, per);
        reg_write(2'd1, {5'b10000, code});
        reg_write(2'd0, 8'h01);
        wait_req(expd * 2 + 50, seen);
        t1 = cyc;
        for (int i = 0; i < 100 && ref_req; i++) @(negedge clk);
        wait_req(expd * 2 + 50, seen);
        t2 = cyc;
        check("R3 request spacing", t2 - t1, expd);
    endtask

    task automatic t_counter();
        int over = 0;
        bit saw_top = 1'b0;
        quiesce();
        ref_gnt = 1'b1;
        reg_write(2'd1, 8'h00);
        check("R5 flag cleared by write with bit7=0", match_flag, 0);
        reg_write(2'd2, 8'd3);
        reg_write(2'd1, 8'h81);
        reg_write(2'd0, 8'h01);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (interval_count > 3) over++;
            if (interval_count == 3) saw_top = 1'b1;
        end
        check("R4 count bounded by period", over, 0);
        check("R4 count reached period", saw_top, 1);
        check("R4 flag set on match", match_flag, 1);
    endtask

    task automatic t_flag();
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h80);
        check("R5 write with bit7=1 keeps flag", match_flag, 1);
        reg_write(2'd1, 8'h00);
        check("R5 write with bit7=0 clears flag", match_flag, 0);
    endtask

    task automatic t_burst(input logic [2:0] bcode, input int n);
        bit seen;
        quiesce();
        ref_gnt = 1'b1;
        reg_write(2'd2, 8'd7);
        reg_write(2'd1, {2'b10, bcode, 3'd3});
        reg_write(2'd0, 8'h01);
        wait_req(600, seen);
        check("R8 request seen", seen, 1);
        check_train($sformatf("R8 R7 burst code %0d", bcode), n);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_grant_wait();
        bit seen;
        int errs = 0;
        quiesce();
        ref_gnt = 1'b0;
        reg_write(2'd2, 8'd2);
        reg_write(2'd1, 8'h81);
        reg_write(2'd0, 8'h01);
        wait_req(100, seen);
        check("R6 request raised", seen, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!ref_req || !ras_n || !cas_n) errs++;
        end
        check("R6 strobes idle until grant", errs, 0);
        ref_gnt = 1'b1;
        reg_write(2'd1, 8'h80);
        for (int i = 0; i < 40 && ref_req; i++) @(negedge clk);
        check("R6 granted refresh completes", ref_req, 0);
    endtask

    task automatic t_self();
        bit seen;
        int errs = 0;
        quiesce();
        ref_gnt = 1'b0;
        reg_write(2'd1, 8'h81);
        reg_write(2'd0, 8'h03);
        wait_req(20, seen);
        check("R10 self request", seen, 1);
        check("R10 strobes high before grant", {ras_n, cas_n}, 3);
        ref_gnt = 1'b1;
        @(negedge clk);
        check("R10 CAS low first", {ras_n, cas_n}, 2);
        @(negedge clk);
        check("R10 RAS follows", {ras_n, cas_n}, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ras_n || cas_n || !ref_req) errs++;
            if (interval_count != 0) errs++;
        end
        check("R10 R12 held low, count zero", errs, 0);
        reg_write(2'd1, 8'h80);
        reg_write(2'd0, 8'h01);
        for (int i = 0; i < 5 && ras_n == 0; i++) @(negedge clk);
        check("R11 strobes rise together", {ras_n, cas_n}, 3);
        check("R11 request held in precharge", ref_req, 1);
        @(negedge clk);
        check("R11 second precharge clock", {ref_req, ras_n, cas_n}, 7);
        @(negedge clk);
        check("R11 request released", ref_req, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_code_zero();
        t_interval(3'd2, 8'd3, 32);
        t_interval(3'd1, 8'd9, 20);
        t_interval(3'd7, 8'd0, 4096);
        t_counter();
        t_flag();
        t_burst(3'd0, 1);
        t_burst(3'd1, 2);
        t_burst(3'd2, 4);
        t_burst(3'd3, 6);
        t_burst(3'd4, 8);
        t_burst(3'd6, 8);
        t_grant_wait();
        t_self();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule